// File: doc/BRIEF.md
# Address-Decoded Message Interrupt Controller

This block gathers message-signalled interrupts for several cores. A message is a single write on a plain valid/address/data port. The block takes the destination core and the vector number from the write address; the data word carries nothing. Each core owns 256 edge-style pending bits. A message sets one bit in the named core's bank. A repeat of a bit that is already set merges into it.

Software drains a core by reading that core's claim port again and again. Each read hands back the lowest pending vector and retires it in the same clock. When the bank is empty, the read returns a word flagged as invalid. The pending banks can also be inspected as 64-bit slices. One enable register gates the per-core interrupt lines. It does not gate message capture or claims.

Top module: `vmsg_irq_ctrl`

## Requirements
- R1: A message with `msg_valid_i` high takes its vector from address bits [11:4] and its core number from address bits [27:12]. The data word, address bits [3:0] and address bits [31:28] have no effect.
- R2: `stat_rdata_o` shows the bank of core `stat_core_i`, slice `stat_word_i`. Bit b of slice w is vector 64*w+b.
- R3: A claim (`claim_re_i` high for one cycle) of a non-empty bank retires the lowest-numbered pending vector of that core. After that edge, `claim_rdata_o` holds the vector in bits [7:0], with bits [31:8] zero.
- R4: A claim of an empty bank returns 0x8000_0000 (bit 31 set means invalid) and changes no state.
- R5: Repeated messages to a vector that is already pending merge into one pending bit, so one claim drains it.
- R6: A message and a claim that hit the same vector of the same core in one cycle return that vector, and it stays pending.
- R7: `irq_o[c]` is high exactly when the enable register is set and core c has any pending bit. A control write (`ctrl_we_i`) loads the enable from `ctrl_en_i` for the next cycle.
- R8: A message whose core number is not below NUM_CORES is dropped and sets no bit anywhere.
- R9: While the enable is clear, messages are still captured and claimable; only `irq_o` is held low.
- R10: After reset all banks are empty, the enable is clear, `irq_o` is zero and `claim_rdata_o` is 0x8000_0000.
- R11: A claim on one core leaves the banks of all other cores unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Message write strobe |
| msg_addr_i | input | 32 | Message address carrying core and vector |
| msg_data_i | input | 32 | Message data, ignored |
| ctrl_we_i | input | 1 | Enable register write strobe |
| ctrl_en_i | input | 1 | Enable value to load |
| claim_re_i | input | 1 | Claim read strobe |
| claim_core_i | input | 2 | Core whose bank is claimed |
| claim_rdata_o | output | 32 | Claim result, registered |
| stat_core_i | input | 2 | Core selected for pending inspection |
| stat_word_i | input | 2 | 64-bit slice selected |
| stat_rdata_o | output | 64 | Pending slice |
| irq_o | output | 4 | Per-core interrupt lines |

## Verification
The bench builds the block with its defaults: four cores, 256 vectors, 64-bit slices and a 16-bit core field. With four cores a core number of 4, or one with high bits set, lands beyond the last bank, so the drop rule can be checked. The 256-vector depth puts vector 255 in slice 3, bit 63, and lets vectors in three slices compete in one claim order. Collision and merge cases are driven in a single cycle on one core while a neighbour holds the same vector number.

// File: rtl/vmsg_pkg.sv
package vmsg_pkg;
  localparam int unsigned CLAIM_W     = 32;
  localparam int unsigned INVALID_BIT = 31;
  localparam int unsigned VEC_FIELD_W = 8;
  localparam int unsigned VEC_LSB     = 4;

  function automatic logic [CLAIM_W-1:0] claim_word(input logic found,
                                                    input logic [VEC_FIELD_W-1:0] vec);
    logic [CLAIM_W-1:0] w;
    w = '0;
    if (found) w[VEC_FIELD_W-1:0] = vec;
    else       w[INVALID_BIT] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/vmsg_addr_dec.sv
module vmsg_addr_dec #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CORE_ID_W = 16,
  parameter int unsigned VEC_W     = 8,
  localparam int unsigned CORE_IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned CORE_LSB   = vmsg_pkg::VEC_LSB + VEC_W
) (
  input  logic                  msg_valid_i,
  input  logic [ADDR_W-1:0]     msg_addr_i,
  output logic                  ok_o,
  output logic [CORE_IDX_W-1:0] core_o,
  output logic [VEC_W-1:0]      vec_o
);
  logic [CORE_ID_W-1:0] core_id;
  wire unused_addr = ^{msg_addr_i[vmsg_pkg::VEC_LSB-1:0],
                       msg_addr_i[ADDR_W-1:CORE_LSB+CORE_ID_W]};

  assign core_id = msg_addr_i[CORE_LSB +: CORE_ID_W];
  assign vec_o   = msg_addr_i[vmsg_pkg::VEC_LSB +: VEC_W];
  assign core_o  = core_id[CORE_IDX_W-1:0];
  assign ok_o    = msg_valid_i && (core_id < CORE_ID_W'(NUM_CORES));
endmodule

// File: rtl/vmsg_lowest_find.sv
module vmsg_lowest_find #(
  parameter int unsigned N = 256,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/vmsg_core_bank.sv
module vmsg_core_bank #(
  parameter int unsigned NUM_VECTORS = 256,
  localparam int unsigned VEC_W = $clog2(NUM_VECTORS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   set_i,
  input  logic [VEC_W-1:0]       set_vec_i,
  input  logic                   clr_i,
  output logic [NUM_VECTORS-1:0] pend_o,
  output logic                   low_found_o,
  output logic [VEC_W-1:0]       low_vec_o
);
  logic [NUM_VECTORS-1:0] pend_q, set_mask, clr_mask;

  assign set_mask = set_i ? (NUM_VECTORS'(1) << set_vec_i) : '0;
  assign clr_mask = clr_i ? (NUM_VECTORS'(1) << low_vec_o) : '0;

  // set wins over clear so a colliding message is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_mask) | set_mask;
  end

  vmsg_lowest_find #(.N(NUM_VECTORS)) u_find (
    .vec_i   (pend_q),
    .found_o (low_found_o),
    .idx_o   (low_vec_o)
  );

  assign pend_o = pend_q;
endmodule

// File: rtl/vmsg_irq_ctrl.sv
module vmsg_irq_ctrl #(
  parameter int unsigned NUM_CORES   = 4,
  parameter int unsigned NUM_VECTORS = 256,
  parameter int unsigned WORD_W      = 64,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CORE_ID_W   = 16,
  localparam int unsigned CORE_IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned VEC_W      = $clog2(NUM_VECTORS),
  localparam int unsigned NUM_WORDS  = NUM_VECTORS / WORD_W,
  localparam int unsigned WSEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        msg_valid_i,
  input  logic [ADDR_W-1:0]           msg_addr_i,
  input  logic [DATA_W-1:0]           msg_data_i,
  input  logic                        ctrl_we_i,
  input  logic                        ctrl_en_i,
  input  logic                        claim_re_i,
  input  logic [CORE_IDX_W-1:0]       claim_core_i,
  output logic [vmsg_pkg::CLAIM_W-1:0] claim_rdata_o,
  input  logic [CORE_IDX_W-1:0]       stat_core_i,
  input  logic [WSEL_W-1:0]           stat_word_i,
  output logic [WORD_W-1:0]           stat_rdata_o,
  output logic [NUM_CORES-1:0]        irq_o
);
  logic                   dec_ok;
  logic [CORE_IDX_W-1:0]  dec_core;
  logic [VEC_W-1:0]       dec_vec;
  logic                   en_q;
  logic [NUM_VECTORS-1:0] pend [NUM_CORES];
  logic [NUM_CORES-1:0]   low_found;
  logic [VEC_W-1:0]       low_vec [NUM_CORES];
  logic                   sel_found;
  logic [VEC_W-1:0]       sel_vec;
  wire unused_data = ^msg_data_i;

  vmsg_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES), .CORE_ID_W(CORE_ID_W), .VEC_W(VEC_W)
  ) u_dec (
    .msg_valid_i (msg_valid_i),
    .msg_addr_i  (msg_addr_i),
    .ok_o        (dec_ok),
    .core_o      (dec_core),
    .vec_o       (dec_vec)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic hit_set, hit_clr;
    assign hit_set = dec_ok && (dec_core == CORE_IDX_W'(c));
    assign hit_clr = claim_re_i && (claim_core_i == CORE_IDX_W'(c)) && low_found[c];

    vmsg_core_bank #(.NUM_VECTORS(NUM_VECTORS)) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .set_i       (hit_set),
      .set_vec_i   (dec_vec),
      .clr_i       (hit_clr),
      .pend_o      (pend[c]),
      .low_found_o (low_found[c]),
      .low_vec_o   (low_vec[c])
    );

    assign irq_o[c] = en_q && low_found[c];
  end

  always_comb begin
    sel_found    = 1'b0;
    sel_vec      = '0;
    stat_rdata_o = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (claim_core_i == CORE_IDX_W'(c)) begin
        sel_found = low_found[c];
        sel_vec   = low_vec[c];
      end
      if (stat_core_i == CORE_IDX_W'(c)) begin
        for (int w = 0; w < NUM_WORDS; w++) begin
          if (stat_word_i == WSEL_W'(w)) stat_rdata_o = pend[c][w*WORD_W +: WORD_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q          <= 1'b0;
      claim_rdata_o <= vmsg_pkg::claim_word(1'b0, '0);
    end else begin
      if (ctrl_we_i)  en_q <= ctrl_en_i;
      if (claim_re_i) claim_rdata_o <= vmsg_pkg::claim_word(sel_found,
                                         vmsg_pkg::VEC_FIELD_W'(sel_vec));
    end
  end
endmodule

// File: rtl/vmsg_irq_ctrl_chk.sv
module vmsg_irq_ctrl_chk #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 32,
  localparam int unsigned CORE_IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 msg_valid_i,
  input logic [ADDR_W-1:0]    msg_addr_i,
  input logic                 ctrl_we_i,
  input logic                 ctrl_en_i,
  input logic [31:0]          claim_rdata_o,
  input logic [NUM_CORES-1:0] irq_o,
  input logic                 en_q
);
  logic [15:0]           msg_core;
  logic                  exp_hit_q;
  logic [CORE_IDX_W-1:0] exp_core_q;
  logic                  far_msg;

  assign msg_core = msg_addr_i[27:12];
  assign far_msg  = msg_valid_i && (msg_core >= 16'(NUM_CORES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_hit_q  <= 1'b0;
      exp_core_q <= '0;
    end else begin
      exp_hit_q  <= msg_valid_i && en_q && !ctrl_we_i && !far_msg;
      exp_core_q <= msg_core[CORE_IDX_W-1:0];
    end
  end

  p_claim_fmt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_rdata_o[30:8] == '0);

  p_empty_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_rdata_o[31] |-> claim_rdata_o[7:0] == '0);

  p_irq_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && !ctrl_en_i |=> irq_o == '0);

  p_deliver_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_hit_q |-> irq_o[exp_core_q]);

  p_irq_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~$past(irq_o)) != '0 |-> $past(msg_valid_i || ctrl_we_i));

  p_drop_far_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    far_msg && !ctrl_we_i |=> (irq_o & ~$past(irq_o)) == '0);
endmodule

bind vmsg_irq_ctrl vmsg_irq_ctrl_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .msg_valid_i   (msg_valid_i),
  .msg_addr_i    (msg_addr_i),
  .ctrl_we_i     (ctrl_we_i),
  .ctrl_en_i     (ctrl_en_i),
  .claim_rdata_o (claim_rdata_o),
  .irq_o         (irq_o),
  .en_q          (en_q)
);

// File: tb/vmsg_irq_ctrl_test.sv
`timescale 1ns/1ps
module vmsg_irq_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        msg_valid_i = 1'b0;
  logic [31:0] msg_addr_i = '0;
  logic [31:0] msg_data_i = '0;
  logic        ctrl_we_i = 1'b0;
  logic        ctrl_en_i = 1'b0;
  logic        claim_re_i = 1'b0;
  logic [1:0]  claim_core_i = '0;
  logic [31:0] claim_rdata_o;
  logic [1:0]  stat_core_i = '0;
  logic [1:0]  stat_word_i = '0;
  logic [63:0] stat_rdata_o;
  logic [3:0]  irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [31:0] INVALID = 32'h8000_0000;

  always #4 clk_i = ~clk_i;

  vmsg_irq_ctrl uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input logic [15:0] core, input logic [7:0] vec);
    return {4'h0, core, vec, 4'h0};
  endfunction

  task automatic send(input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk_i);
    msg_valid_i = 1'b1; msg_addr_i = addr; msg_data_i = data;
    @(negedge clk_i);
    msg_valid_i = 1'b0;
  endtask

  task automatic claim(input logic [1:0] core, output logic [31:0] rd);
    @(negedge clk_i);
    claim_re_i = 1'b1; claim_core_i = core;
    @(negedge clk_i);
    claim_re_i = 1'b0;
    rd = claim_rdata_o;
  endtask

  task automatic stat(input logic [1:0] core, input logic [1:0] w, output logic [63:0] v);
    stat_core_i = core; stat_word_i = w;
    #1 v = stat_rdata_o;
  endtask

  task automatic set_en(input logic b);
    @(negedge clk_i);
    ctrl_we_i = 1'b1; ctrl_en_i = b;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    chk(irq_o == 4'b0, "R10 irq", 64'(irq_o), 64'h0);
    chk(claim_rdata_o == INVALID, "R10 claim", 64'(claim_rdata_o), 64'(INVALID));
    for (int c = 0; c < 4; c++) begin
      stat(c[1:0], 2'd0, v);
      chk(v == 64'h0, "R10 bank", v, 64'h0);
    end
  endtask

  task automatic t_decode;
    logic [63:0] v;
    // vector 0x9A = 154 -> slice 2, bit 26; junk in data, low and top address bits
    send(mk_addr(16'd2, 8'h9A) | 32'hA000_000F, 32'hDEAD_BEEF);
    stat(2'd2, 2'd2, v);
    chk(v == (64'h1 << 26), "R1 R2 core2 slice2", v, 64'h1 << 26);
    stat(2'd1, 2'd2, v);
    chk(v == 64'h0, "R1 other core", v, 64'h0);
    stat(2'd2, 2'd3, v);
    chk(v == 64'h0, "R2 other slice", v, 64'h0);
  endtask

  task automatic t_order;
    logic [31:0] rd;
    logic [63:0] v;
    send(mk_addr(16'd1, 8'd200), 32'h0);
    send(mk_addr(16'd1, 8'd5), 32'h0);
    send(mk_addr(16'd1, 8'd70), 32'h0);
    stat(2'd1, 2'd1, v);
    chk(v == (64'h1 << 6), "R2 vec70 slice1", v, 64'h1 << 6);
    claim(2'd1, rd); chk(rd == 32'd5,   "R3 first",  64'(rd), 64'd5);
    claim(2'd1, rd); chk(rd == 32'd70,  "R3 second", 64'(rd), 64'd70);
    claim(2'd1, rd); chk(rd == 32'd200, "R3 third",  64'(rd), 64'd200);
    claim(2'd1, rd); chk(rd == INVALID, "R4 empty",  64'(rd), 64'(INVALID));
    claim(2'd2, rd); chk(rd == 32'd154, "R3 core2",  64'(rd), 64'd154);
    claim(2'd2, rd); chk(rd == INVALID, "R4 empty2", 64'(rd), 64'(INVALID));
  endtask

  task automatic t_merge;
    logic [31:0] rd;
    send(mk_addr(16'd0, 8'd33), 32'h0);
    send(mk_addr(16'd0, 8'd33), 32'h0);
    claim(2'd0, rd); chk(rd == 32'd33,  "R5 once",   64'(rd), 64'd33);
    claim(2'd0, rd); chk(rd == INVALID, "R5 merged", 64'(rd), 64'(INVALID));
  endtask

  task automatic t_collide;
    logic [31:0] rd;
    logic [63:0] v;
    send(mk_addr(16'd3, 8'd10), 32'h0);
    @(negedge clk_i);
    msg_valid_i = 1'b1; msg_addr_i = mk_addr(16'd3, 8'd10);
    claim_re_i = 1'b1; claim_core_i = 2'd3;
    @(negedge clk_i);
    msg_valid_i = 1'b0; claim_re_i = 1'b0;
    chk(claim_rdata_o == 32'd10, "R6 returned", 64'(claim_rdata_o), 64'd10);
    stat(2'd3, 2'd0, v);
    chk(v == (64'h1 << 10), "R6 kept", v, 64'h1 << 10);
    claim(2'd3, rd); chk(rd == 32'd10,  "R6 reclaim", 64'(rd), 64'd10);
    claim(2'd3, rd); chk(rd == INVALID, "R6 drained", 64'(rd), 64'(INVALID));
  endtask

  task automatic t_drop;
    logic [63:0] v;
    set_en(1'b1);
    send(mk_addr(16'd4, 8'd1), 32'h0);
    send(mk_addr(16'h0100, 8'd1), 32'h0);
    chk(irq_o == 4'b0, "R8 irq", 64'(irq_o), 64'h0);
    for (int c = 0; c < 4; c++) begin
      stat(c[1:0], 2'd0, v);
      chk(v == 64'h0, "R8 bank", v, 64'h0);
    end
    set_en(1'b0);
  endtask

  task automatic t_enable;
    logic [31:0] rd;
    logic [63:0] v;
    send(mk_addr(16'd0, 8'd3), 32'h0);
    chk(irq_o == 4'b0, "R9 gated", 64'(irq_o), 64'h0);
    stat(2'd0, 2'd0, v);
    chk(v == 64'h8, "R9 captured", v, 64'h8);
    set_en(1'b1);
    chk(irq_o == 4'b0001, "R7 on", 64'(irq_o), 64'h1);
    send(mk_addr(16'd2, 8'd255), 32'h0);
    chk(irq_o == 4'b0101, "R7 core2", 64'(irq_o), 64'h5);
    stat(2'd2, 2'd3, v);
    chk(v == (64'h1 << 63), "R2 vec255", v, 64'h1 << 63);
    claim(2'd0, rd); chk(rd == 32'd3, "R9 claim", 64'(rd), 64'd3);
    chk(irq_o == 4'b0100, "R7 drop core0", 64'(irq_o), 64'h4);
    set_en(1'b0);
    chk(irq_o == 4'b0000, "R7 off", 64'(irq_o), 64'h0);
    claim(2'd2, rd); chk(rd == 32'd255, "R3 vec255", 64'(rd), 64'd255);
  endtask

  task automatic t_isolate;
    logic [31:0] rd;
    logic [63:0] v;
    send(mk_addr(16'd0, 8'd7), 32'h0);
    send(mk_addr(16'd1, 8'd7), 32'h0);
    claim(2'd0, rd); chk(rd == 32'd7, "R11 claim", 64'(rd), 64'd7);
    stat(2'd1, 2'd0, v);
    chk(v == 64'h80, "R11 neighbour", v, 64'h80);
    stat(2'd0, 2'd0, v);
    chk(v == 64'h0, "R11 own", v, 64'h0);
    claim(2'd1, rd); chk(rd == 32'd7, "R11 drain", 64'(rd), 64'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_decode();
    t_order();
    t_merge();
    t_collide();
    t_drop();
    t_enable();
    t_isolate();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule